// File: doc/BRIEF.md
# ARINC 429 Word Receiver with Label Filter

This block takes the two legs from an external ARINC 429 line receiver, finds each bit from the return-to-zero waveform, and rebuilds 32-bit words in their field positions. The first eight bits on the line form the label. They arrive in reverse order and are put back so that bit 1 sits at index 0. Every later bit goes straight to its own index.

A word is framed by a run of Null on the line. When a framed word is complete, its label selects one entry in a software-written enable table. Words with an enabled label are pushed into a small receive FIFO together with a parity status bit. A CPU pops the FIFO through a first-word-fall-through read port. Short words, overlong words, bits with both legs driven and FIFO overruns each set a sticky status flag. A status read clears those flags.

One port selects the bit rate for this channel: the fast rate, or the half-speed rate. The bit period is set by a parameter counted in clocks, so any sampling clock can be mapped onto it.

Top module: `a429_rx_top`

## Requirements
- R1: After reset the FIFO is empty (`fifoEmpty`=1), all three flags (`overrun`, `frameErr`, `lineErr`) are 0, and every label entry is disabled, so any word received before a table write is dropped.
- R2: The first eight bits received are placed at word indices 7 down to 0. Received bits 9 to 32 are placed at indices 8 to 31. `rdWord[0]` is word bit 1 and `rdWord[31]` is bit 32, the parity bit.
- R3: A bit is taken from `legHi` a quarter bit period after the line leaves Null, which is the middle of its driven half. The bit period is `BIT_CLKS` clocks when `slowRate`=0 and `2*BIT_CLKS` clocks when `slowRate`=1.
- R4: A word is accepted only if exactly 32 bits are followed by Null lasting `GAP_BITS` bit periods. Fewer than 32 bits, or a 33rd bit before the gap, discards the word and sets `frameErr`.
- R5: A stored word with an even number of ones across all 32 bits is read out with `rdParErr`=1. A word with odd overall parity is read out with `rdParErr`=0. Both kinds are stored.
- R6: The label `rdWord[7:0]` (word bits 1 to 8) indexes the enable table. A CPU write with `cpuLblWe`=1 sets entry `cpuLblAddr` to `cpuLblEn`. A word whose entry is 0 never enters the FIFO.
- R7: If both legs are high at the sample point, the word in progress is discarded and `lineErr` is set.
- R8: Stored words are read in arrival order. `rdWord` and `rdParErr` show the oldest entry while `fifoEmpty`=0. `cpuRdEn` pops that entry on the clock edge.
- R9: An enabled word that arrives while the FIFO is full is dropped, the stored contents are kept, and `overrun` is set. `overrun` stays set until a `cpuStatRd` pulse clears it.
- R10: A `cpuStatRd` pulse clears `frameErr` and `lineErr`. If the same cycle also sets a flag, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| legHi | input | 1 | High leg from the line receiver (a 1 bit) |
| legLo | input | 1 | Low leg from the line receiver (a 0 bit) |
| slowRate | input | 1 | 0: fast rate, 1: half rate |
| cpuLblWe | input | 1 | Write strobe for the label enable table |
| cpuLblAddr | input | LABEL_W | Label entry to write |
| cpuLblEn | input | 1 | Enable value written to the entry |
| cpuRdEn | input | 1 | Pop the oldest FIFO entry |
| cpuStatRd | input | 1 | Status read; clears the sticky flags |
| rdWord | output | 32 | Oldest stored word, with bit 1 at index 0 |
| rdParErr | output | 1 | Parity status of the oldest stored word |
| fifoEmpty | output | 1 | FIFO holds no words |
| fifoFull | output | 1 | FIFO holds FIFO_DEPTH words |
| overrun | output | 1 | Sticky: an enabled word was dropped because the FIFO was full |
| frameErr | output | 1 | Sticky: a word was too short or too long |
| lineErr | output | 1 | Sticky: both legs were high at a sample point |

## Verification
The bench builds the block with `BIT_CLKS`=8, `GAP_BITS`=2 and `FIFO_DEPTH`=4. With these values a fast word takes under 300 clocks and a half-rate word under 600, so words at both rates, and words with mixed labels and parity, fit easily in one run. A depth of four makes a full FIFO reachable with a fifth word, which exercises the overrun path. Bit positions are checked through asymmetric labels. Short words, overlong words and a bit with both legs high are each injected once.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);

  // strobes from the framing control to the datapath
  typedef struct packed {
    logic             putBit;
    logic             bitVal;
    logic [IDX_W-1:0] bitIdx;
    logic             commit;
    logic             frameBad;
    logic             lineBad;
  } rxStb_t;
endpackage

// File: rtl/a429_rx_fifo.sv
module a429_rx_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPop;

  assign empty = (count == '0);
  assign full  = (count == CMAX);
  assign doPop = pop && !empty;
  assign dout  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)  wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: occupancy never exceeds the depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    count <= CMAX);
  // R9: the datapath gates pushes on a full FIFO
  p_push_room_r9: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
endmodule

// File: rtl/a429_rx_ctrl.sv
module a429_rx_ctrl
  import a429_rx_pkg::*;
#(
  parameter int BIT_CLKS = 8,
  parameter int GAP_BITS = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   legHi,
  input  logic   legLo,
  input  logic   slowRate,
  output rxStb_t stb
);
  localparam int SLOW_CLKS = 2 * BIT_CLKS;
  localparam int GAP_MAX   = GAP_BITS * SLOW_CLKS;
  localparam int CNT_W     = $clog2(GAP_MAX + 1);
  localparam logic [CNT_W-1:0] Q_FAST = CNT_W'(BIT_CLKS / 4 - 1);
  localparam logic [CNT_W-1:0] Q_SLOW = CNT_W'(SLOW_CLKS / 4 - 1);
  localparam logic [CNT_W-1:0] G_FAST = CNT_W'(GAP_BITS * BIT_CLKS);
  localparam logic [CNT_W-1:0] G_SLOW = CNT_W'(GAP_MAX);
  localparam logic [5:0] FULL_CNT = 6'(WORD_W);

  logic [1:0]       syncHi, syncLo;
  logic             hi, lo, isNull, prevNull, lineEdge;
  logic             armed, dropping;
  logic [CNT_W-1:0] phaseCnt, nullCnt, quarterLd, gapLim;
  logic [5:0]       bitCnt;
  logic             sampleNow, gapNow;

  assign hi        = syncHi[1];
  assign lo        = syncLo[1];
  assign isNull    = !hi && !lo;
  assign lineEdge  = prevNull && !isNull;
  assign quarterLd = slowRate ? Q_SLOW : Q_FAST;
  assign gapLim    = slowRate ? G_SLOW : G_FAST;
  assign sampleNow = armed && (phaseCnt == '0) && !isNull;
  assign gapNow    = isNull && (nullCnt == gapLim - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncHi   <= '0;
      syncLo   <= '0;
      prevNull <= 1'b1;
      armed    <= 1'b0;
      phaseCnt <= '0;
      nullCnt  <= '0;
    end else begin
      syncHi   <= {syncHi[0], legHi};
      syncLo   <= {syncLo[0], legLo};
      prevNull <= isNull;
      if (lineEdge) begin
        armed    <= 1'b1;
        phaseCnt <= quarterLd;
      end else if (armed) begin
        if (phaseCnt == '0) armed <= 1'b0;
        else                phaseCnt <= phaseCnt - 1'b1;
      end
      if (!isNull)               nullCnt <= '0;
      else if (nullCnt < gapLim) nullCnt <= nullCnt + 1'b1;
    end
  end

  always_comb begin
    stb = '0;
    if (sampleNow && !dropping) begin
      if (hi && lo)                  stb.lineBad  = 1'b1;
      else if (bitCnt == FULL_CNT)   stb.frameBad = 1'b1;
      else begin
        stb.putBit = 1'b1;
        stb.bitVal = hi;
        stb.bitIdx = (bitCnt < 6'd8) ? IDX_W'(6'd7 - bitCnt) : bitCnt[IDX_W-1:0];
      end
    end
    if (gapNow && !dropping) begin
      if (bitCnt == FULL_CNT)  stb.commit   = 1'b1;
      else if (bitCnt != '0)   stb.frameBad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      dropping <= 1'b0;
    end else if (gapNow) begin
      bitCnt   <= '0;
      dropping <= 1'b0;
    end else if (sampleNow && !dropping) begin
      if ((hi && lo) || bitCnt == FULL_CNT) begin
        bitCnt   <= '0;
        dropping <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R4: the bit count never passes a full word
  p_bitcnt_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);
  // R4: a dropped word leaves no partial count behind
  p_drop_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    dropping |-> bitCnt == '0);
endmodule

// File: rtl/a429_rx_dp.sv
module a429_rx_dp
  import a429_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LABEL_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxStb_t             stb,
  input  logic               cpuLblWe,
  input  logic [LABEL_W-1:0] cpuLblAddr,
  input  logic               cpuLblEn,
  input  logic               cpuRdEn,
  input  logic               cpuStatRd,
  output logic [WORD_W-1:0]  rdWord,
  output logic               rdParErr,
  output logic               fifoEmpty,
  output logic               fifoFull,
  output logic               overrun,
  output logic               frameErr,
  output logic               lineErr
);
  localparam int LABELS = 2 ** LABEL_W;

  logic [WORD_W-1:0] wordReg;
  logic [LABELS-1:0] lblTbl;
  logic              parBad, wantStore, push;

  assign parBad    = ~^wordReg;
  assign wantStore = stb.commit && lblTbl[wordReg[LABEL_W-1:0]];
  assign push      = wantStore && !fifoFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg  <= '0;
      lblTbl   <= '0;
      overrun  <= 1'b0;
      frameErr <= 1'b0;
      lineErr  <= 1'b0;
    end else begin
      if (stb.putBit) wordReg[stb.bitIdx] <= stb.bitVal;
      if (cpuLblWe)   lblTbl[cpuLblAddr] <= cpuLblEn;
      if (wantStore && fifoFull) overrun  <= 1'b1;
      else if (cpuStatRd)        overrun  <= 1'b0;
      if (stb.frameBad)          frameErr <= 1'b1;
      else if (cpuStatRd)        frameErr <= 1'b0;
      if (stb.lineBad)           lineErr  <= 1'b1;
      else if (cpuStatRd)        lineErr  <= 1'b0;
    end
  end

  a429_rx_fifo #(.W(WORD_W + 1), .DEPTH(FIFO_DEPTH)) uFifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (push),
    .din   ({parBad, wordReg}),
    .pop   (cpuRdEn),
    .dout  ({rdParErr, rdWord}),
    .empty (fifoEmpty),
    .full  (fifoFull)
  );

  // R9: overrun only rises on the cycle after a completed word
  p_overrun_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(stb.commit));
  // R7: lineErr only rises after a sample with both legs high
  p_line_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineErr) |-> $past(stb.lineBad));
endmodule

// File: rtl/a429_rx_top.sv
module a429_rx_top #(
  parameter int BIT_CLKS   = 8,
  parameter int GAP_BITS   = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int LABEL_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               legHi,
  input  logic               legLo,
  input  logic               slowRate,
  input  logic               cpuLblWe,
  input  logic [LABEL_W-1:0] cpuLblAddr,
  input  logic               cpuLblEn,
  input  logic               cpuRdEn,
  input  logic               cpuStatRd,
  output logic [31:0]        rdWord,
  output logic               rdParErr,
  output logic               fifoEmpty,
  output logic               fifoFull,
  output logic               overrun,
  output logic               frameErr,
  output logic               lineErr
);
  a429_rx_pkg::rxStb_t stb;

  a429_rx_ctrl #(.BIT_CLKS(BIT_CLKS), .GAP_BITS(GAP_BITS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .legHi    (legHi),
    .legLo    (legLo),
    .slowRate (slowRate),
    .stb      (stb)
  );

  a429_rx_dp #(.FIFO_DEPTH(FIFO_DEPTH), .LABEL_W(LABEL_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cpuLblWe   (cpuLblWe),
    .cpuLblAddr (cpuLblAddr),
    .cpuLblEn   (cpuLblEn),
    .cpuRdEn    (cpuRdEn),
    .cpuStatRd  (cpuStatRd),
    .rdWord     (rdWord),
    .rdParErr   (rdParErr),
    .fifoEmpty  (fifoEmpty),
    .fifoFull   (fifoFull),
    .overrun    (overrun),
    .frameErr   (frameErr),
    .lineErr    (lineErr)
  );
endmodule

// File: tb/sim_a429_rx_top.sv
module sim_a429_rx_top;
  localparam int BIT_CLKS = 8;
  localparam int DEPTH    = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic legHi = 0, legLo = 0, slowRate = 0;
  logic cpuLblWe = 0, cpuLblEn = 0, cpuRdEn = 0, cpuStatRd = 0;
  logic [7:0]  cpuLblAddr = '0;
  logic [31:0] rdWord;
  logic rdParErr, fifoEmpty, fifoFull, overrun, frameErr, lineErr;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  a429_rx_top #(.BIT_CLKS(BIT_CLKS), .GAP_BITS(2), .FIFO_DEPTH(DEPTH), .LABEL_W(8)) u0 (
    .clk(clk), .rstN(rstN), .legHi(legHi), .legLo(legLo), .slowRate(slowRate),
    .cpuLblWe(cpuLblWe), .cpuLblAddr(cpuLblAddr), .cpuLblEn(cpuLblEn),
    .cpuRdEn(cpuRdEn), .cpuStatRd(cpuStatRd), .rdWord(rdWord), .rdParErr(rdParErr),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .overrun(overrun),
    .frameErr(frameErr), .lineErr(lineErr));

  // {slowRate, expectStored, word}
  localparam logic [33:0] VEC [7] = '{
    34'h1_1234_5635, 34'h1_0000_0E02, 34'h3_DEAD_BEA1, 34'h0_FFFF_FF77,
    34'h2_0123_4577, 34'h1_8000_0035, 34'h3_C000_0102 };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setLabel(input logic [7:0] lbl, input logic en);
    @(negedge clk); cpuLblWe = 1; cpuLblAddr = lbl; cpuLblEn = en;
    @(negedge clk); cpuLblWe = 0;
  endtask

  // nbits bits; bit number bothAt drives both legs
  task automatic sendWord(input logic [31:0] w, input bit slow, input int nbits, input int bothAt);
    int half;
    half = slow ? BIT_CLKS : BIT_CLKS / 2;
    slowRate = slow;
    for (int k = 0; k < nbits; k++) begin
      logic b;
      b = (k >= 32) ? 1'b1 : (k < 8) ? w[7 - k] : w[k];
      legHi = b || (k == bothAt);
      legLo = !b || (k == bothAt);
      repeat (half) @(negedge clk);
      legHi = 0; legLo = 0;
      repeat (half) @(negedge clk);
    end
    repeat (8 * half + 3) @(negedge clk);
  endtask

  task automatic popWord;
    cpuRdEn = 1; @(negedge clk); cpuRdEn = 0; @(negedge clk);
  endtask

  task automatic statRead;
    cpuStatRd = 1; @(negedge clk); cpuStatRd = 0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(fifoEmpty && !overrun && !frameErr && !lineErr, "R1 reset",
        {fifoEmpty, overrun, frameErr, lineErr}, 4'b1000);
    // R1: table disabled after reset
    sendWord(32'h1234_5635, 0, 32, -1);
    chk(fifoEmpty, "R1 label table clear", fifoEmpty, 1);

    setLabel(8'h35, 1); setLabel(8'h02, 1); setLabel(8'hA1, 1);
    setLabel(8'h77, 1); setLabel(8'h77, 0);

    // vector walk: R2 order, R3 rates, R5 parity, R6 filter, R8 read
    for (int i = 0; i < 7; i++) begin
      logic [31:0] w;
      w = VEC[i][31:0];
      sendWord(w, VEC[i][33], 32, -1);
      if (VEC[i][32]) begin
        chk(!fifoEmpty, "R3 word stored", fifoEmpty, 0);
        chk(rdWord == w, "R2 bit placement", rdWord, w);
        chk(rdParErr == ~^w, "R5 parity status", rdParErr, ~^w);
        popWord();
        chk(fifoEmpty, "R8 pop", fifoEmpty, 1);
      end else begin
        chk(fifoEmpty, "R6 disabled label dropped", fifoEmpty, 1);
      end
    end

    // R4 short word
    sendWord(32'h1234_5635, 0, 20, -1);
    chk(fifoEmpty && frameErr, "R4 short word", {fifoEmpty, frameErr}, 2'b11);
    statRead();
    chk(!frameErr, "R10 frameErr cleared", frameErr, 0);
    // R4 overlong word
    sendWord(32'h1234_5635, 1, 33, -1);
    chk(fifoEmpty && frameErr, "R4 long word", {fifoEmpty, frameErr}, 2'b11);
    statRead();
    // R7 both legs
    sendWord(32'h1234_5635, 0, 32, 12);
    chk(fifoEmpty && lineErr && !frameErr, "R7 line error", {fifoEmpty, lineErr, frameErr}, 3'b110);
    statRead();
    chk(!lineErr, "R10 lineErr cleared", lineErr, 0);
    // recovery after an error
    sendWord(32'h0000_0E02, 0, 32, -1);
    chk(!fifoEmpty && rdWord == 32'h0000_0E02, "R4 recovery", rdWord, 32'h0000_0E02);
    popWord();

    // R9 overrun and R8 order
    for (int i = 0; i <= DEPTH; i++) sendWord(32'h0001_0035 + (i << 16), 0, 32, -1);
    chk(overrun && fifoFull, "R9 overrun set", {overrun, fifoFull}, 2'b11);
    for (int i = 0; i < DEPTH; i++) begin
      chk(rdWord == 32'h0001_0035 + (i << 16), "R8 order after overrun",
          rdWord, 32'h0001_0035 + (i << 16));
      popWord();
    end
    chk(fifoEmpty && overrun, "R9 sticky until status read", {fifoEmpty, overrun}, 2'b11);
    statRead();
    chk(!overrun, "R9 overrun cleared", overrun, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule